// File: doc/BRIEF.md
# PCI bus parity generator and checker

This block produces and checks the even parity bits of a 64-bit multiplexed address/data bus with eight command/byte-enable lines. The bus is split into two halves. The low half is 32 AD lines plus four C/BE lines, and the high half is the upper 32 AD lines plus the upper four C/BE lines. Each half has its own parity bit: the lower parity bit and the 64-bit extension parity bit.

The parity for a cycle is registered and presented on the following cycle. When the local agent drove the bus, the block drives the parity bits with an output enable. When another agent drove the bus, the block compares the parity bits it samples against its own registered value.

A mismatch in a data phase raises a data-error flag, and a mismatch in an address phase raises a system-error flag. Each flag is gated by its own enable input. Two sticky status bits record errors until a write-one-to-clear strobe clears them. Arbitration, target decode and bus turnaround belong to the surrounding interface logic.

Top module: `pci_par_unit`

## Requirements
- R1: While reset is asserted, every output is low: both parity bits, both parity output enables, both error flags and both status bits.
- R2: If `drive_i` is high in cycle N, then in cycle N+1 `par_o` makes the count of ones across `ad_i[31:0]`, `cbe_i[3:0]` (as sampled in N) and `par_o` even. Every AD and C/BE line is included, whether the phase is an address phase with a command or a data phase with byte enables.
- R3: `par_oe_o` is high in cycle N+1 exactly when `drive_i` was high in cycle N. `par_o` is low whenever `par_oe_o` is low.
- R4: `par64_o` covers `ad_i[63:32]` and `cbe_i[7:4]` under the same even rule and the same one-cycle lag. `par64_oe_o` is high in N+1 only if both `drive_i` and `wide_i` were high in N. `par64_o` is low whenever `par64_oe_o` is low.
- R5: Suppose `drive_i` was low in N and `addr_vld_i` or `data_vld_i` was high in N. Then `par_in_i` sampled in N+1 is compared with the parity of the low half from N. `par64_in_i` is compared with the parity of the high half only if `wide_i` was high in N.
- R6: A mismatch found in N+1 for a data phase raises `perr_o` for exactly cycle N+2, and only if `perr_en_i` is high in N+1.
- R7: A mismatch found in N+1 for an address phase raises `serr_o` for exactly cycle N+2, and only if `serr_en_i` is high in N+1.
- R8: Any mismatch from R5 sets `sts_dpe_o` from cycle N+2, whatever the enables. `sts_sse_o` is set in the same cycle that `serr_o` goes high.
- R9: Both status bits stay set until a cycle with `clr_dpe_i` or `clr_sse_i` high, respectively. They read low from the next cycle. A new error in the same cycle as the clear strobe wins and keeps the bit set.
- R10: No compare takes place after a cycle in which the local agent drove the bus, or in which no phase was valid. In those cases `par_in_i` and `par64_in_i` have no effect on the flags or the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ad_i | input | 64 | Address/data lines as seen this cycle |
| cbe_i | input | 8 | Command / byte-enable lines as seen this cycle |
| addr_vld_i | input | 1 | This cycle is a valid address phase |
| data_vld_i | input | 1 | This cycle is a valid data transfer |
| drive_i | input | 1 | The local agent drives AD and C/BE this cycle |
| wide_i | input | 1 | A 64-bit transfer is active this cycle |
| par_in_i | input | 1 | Sampled low-half parity line |
| par64_in_i | input | 1 | Sampled high-half parity line |
| perr_en_i | input | 1 | Data parity error response enable |
| serr_en_i | input | 1 | System error (address parity) enable |
| clr_dpe_i | input | 1 | Write-one strobe that clears the detected-parity status |
| clr_sse_i | input | 1 | Write-one strobe that clears the signalled-system-error status |
| par_o | output | 1 | Low-half parity drive value |
| par_oe_o | output | 1 | Output enable for `par_o` |
| par64_o | output | 1 | High-half parity drive value |
| par64_oe_o | output | 1 | Output enable for `par64_o` |
| perr_o | output | 1 | Data parity error flag |
| serr_o | output | 1 | Address parity system error flag |
| sts_dpe_o | output | 1 | Sticky detected-parity-error status |
| sts_sse_o | output | 1 | Sticky signalled-system-error status |

## Verification
The bench injects wrong parity on only the high bit while the transfer is wide and again while it is narrow. A design that ignores the width qualifier, or checks the upper half all the time, flags the wrong one of the two. It corrupts parity in the cycle right after the local agent drove the bus. A checker that does not gate on ownership then raises flags for its own traffic. Errors are placed with their enable low, which catches a status bit wrongly tied to the flag enable. Clear strobes are issued in the same cycle as a new error, which catches clear-wins priority. Byte-enable and command patterns with idle lanes at one catch parity that drops unused lanes or the C/BE lines. An off-by-one cycle in the lag shows up on every compare.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  localparam int NUM_HALVES = 2;
  localparam int BYTE_W     = 8;

  typedef struct packed {
    logic drive;
    logic addr;
    logic data;
    logic wide;
  } phase_t;

endpackage

// File: rtl/pci_par_rst_sync.sv
module pci_par_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/pci_par_tree.sv
module pci_par_tree
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] be_i,
  output logic            par_o
);

  localparam int LANES = AD_W / BYTE_W;

  logic [LANES-1:0] lane_par;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_par[l] = ^ad_i[l*BYTE_W +: BYTE_W];
  end

  assign par_o = ^{lane_par, be_i};

endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  phase_t                ph_q,
  input  logic [NUM_HALVES-1:0] par_exp,
  input  logic [NUM_HALVES-1:0] par_seen,
  input  logic                  perr_en,
  input  logic                  serr_en,
  output logic                  perr_o,
  output logic                  serr_o,
  output logic                  any_err_o,
  output logic                  sse_set_o
);

  logic [NUM_HALVES-1:0] half_mm;
  logic rx_active;
  logic mism;
  logic data_err;
  logic addr_err;
  logic perr_d, perr_q;
  logic serr_d, serr_q;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    if (h == 0) begin : g_base
      assign half_mm[h] = par_exp[h] ^ par_seen[h];
    end else begin : g_ext
      assign half_mm[h] = ph_q.wide & (par_exp[h] ^ par_seen[h]);
    end
  end

  always_comb begin
    rx_active = ~ph_q.drive & (ph_q.addr | ph_q.data);
    mism      = |half_mm;
    data_err  = rx_active & ph_q.data & mism;
    addr_err  = rx_active & ph_q.addr & mism;
    perr_d    = data_err & perr_en;
    serr_d    = addr_err & serr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      perr_q <= perr_d;
      serr_q <= serr_d;
    end
  end

  assign perr_o    = perr_q;
  assign serr_o    = serr_q;
  assign any_err_o = data_err | addr_err;
  assign sse_set_o = serr_d;

endmodule

// File: rtl/pci_par_sticky.sv
module pci_par_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i | (q_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter int HALF_AD_W   = 32,
  parameter int HALF_BE_W   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_HALVES*HALF_AD_W-1:0] ad_i,
  input  logic [NUM_HALVES*HALF_BE_W-1:0] cbe_i,
  input  logic                            addr_vld_i,
  input  logic                            data_vld_i,
  input  logic                            drive_i,
  input  logic                            wide_i,
  input  logic                            par_in_i,
  input  logic                            par64_in_i,
  input  logic                            perr_en_i,
  input  logic                            serr_en_i,
  input  logic                            clr_dpe_i,
  input  logic                            clr_sse_i,
  output logic                            par_o,
  output logic                            par_oe_o,
  output logic                            par64_o,
  output logic                            par64_oe_o,
  output logic                            perr_o,
  output logic                            serr_o,
  output logic                            sts_dpe_o,
  output logic                            sts_sse_o
);

  logic rst_sync_n;

  pci_par_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  logic [NUM_HALVES-1:0] par_now;
  logic [NUM_HALVES-1:0] par_q;
  logic [NUM_HALVES-1:0] lane_oe;
  logic [NUM_HALVES-1:0] par_seen;
  phase_t ph_d;
  phase_t ph_q;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_tree
    pci_par_tree #(
      .AD_W(HALF_AD_W),
      .BE_W(HALF_BE_W)
    ) u_tree (
      .ad_i (ad_i[h*HALF_AD_W +: HALF_AD_W]),
      .be_i (cbe_i[h*HALF_BE_W +: HALF_BE_W]),
      .par_o(par_now[h])
    );
  end

  always_comb begin
    ph_d.drive = drive_i;
    ph_d.addr  = addr_vld_i;
    ph_d.data  = data_vld_i;
    ph_d.wide  = wide_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      par_q <= '0;
      ph_q  <= '0;
    end else begin
      par_q <= par_now;
      ph_q  <= ph_d;
    end
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_oe
    if (h == 0) begin : g_base
      assign lane_oe[h] = ph_q.drive;
    end else begin : g_ext
      assign lane_oe[h] = ph_q.drive & ph_q.wide;
    end
  end

  assign par_seen   = {par64_in_i, par_in_i};
  assign par_o      = par_q[0] & lane_oe[0];
  assign par_oe_o   = lane_oe[0];
  assign par64_o    = par_q[1] & lane_oe[1];
  assign par64_oe_o = lane_oe[1];

  logic any_err;
  logic sse_set;

  pci_par_check u_check (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ph_q     (ph_q),
    .par_exp  (par_q),
    .par_seen (par_seen),
    .perr_en  (perr_en_i),
    .serr_en  (serr_en_i),
    .perr_o   (perr_o),
    .serr_o   (serr_o),
    .any_err_o(any_err),
    .sse_set_o(sse_set)
  );

  pci_par_sticky u_sts_dpe (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set_i(any_err),
    .clr_i(clr_dpe_i),
    .q_o  (sts_dpe_o)
  );

  pci_par_sticky u_sts_sse (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set_i(sse_set),
    .clr_i(clr_sse_i),
    .q_o  (sts_sse_o)
  );

endmodule

// File: rtl/pci_par_sva.sv
module pci_par_sva #(
  parameter int HALF_AD_W = 32,
  parameter int HALF_BE_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*HALF_AD_W-1:0] ad_i,
  input logic [2*HALF_BE_W-1:0] cbe_i,
  input logic                   drive_i,
  input logic                   wide_i,
  input logic                   perr_en_i,
  input logic                   serr_en_i,
  input logic                   clr_dpe_i,
  input logic                   clr_sse_i,
  input logic                   par_o,
  input logic                   par_oe_o,
  input logic                   par64_o,
  input logic                   par64_oe_o,
  input logic                   perr_o,
  input logic                   serr_o,
  input logic                   sts_dpe_o,
  input logic                   sts_sse_o
);

  assert_par_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |=> ((^{par_o, $past(ad_i[HALF_AD_W-1:0]), $past(cbe_i[HALF_BE_W-1:0])}) == 1'b0));

  assert_par64_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_i && wide_i) |=> ((^{par64_o, $past(ad_i[2*HALF_AD_W-1:HALF_AD_W]),
                                $past(cbe_i[2*HALF_BE_W-1:HALF_BE_W])}) == 1'b0));

  assert_oe_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |=> par_oe_o);

  assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_i |=> (!par_oe_o && !par_o));

  assert_par64_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_i && wide_i) |=> (!par64_oe_o && !par64_o));

  assert_perr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_en_i |=> !perr_o);

  assert_serr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_en_i |=> !serr_o);

  assert_status_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_o || serr_o) |-> sts_dpe_o);

  assert_sse_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> sts_sse_o);

  assert_dpe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_dpe_o && !clr_dpe_i) |=> sts_dpe_o);

  assert_sse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_sse_o && !clr_sse_i) |=> sts_sse_o);

  assert_own_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |=> ##1 (!perr_o && !serr_o));

endmodule

bind pci_par_unit pci_par_sva #(
  .HALF_AD_W(HALF_AD_W),
  .HALF_BE_W(HALF_BE_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ad_i      (ad_i),
  .cbe_i     (cbe_i),
  .drive_i   (drive_i),
  .wide_i    (wide_i),
  .perr_en_i (perr_en_i),
  .serr_en_i (serr_en_i),
  .clr_dpe_i (clr_dpe_i),
  .clr_sse_i (clr_sse_i),
  .par_o     (par_o),
  .par_oe_o  (par_oe_o),
  .par64_o   (par64_o),
  .par64_oe_o(par64_oe_o),
  .perr_o    (perr_o),
  .serr_o    (serr_o),
  .sts_dpe_o (sts_dpe_o),
  .sts_sse_o (sts_sse_o)
);

// File: tb/pci_par_unit_tb.sv
module pci_par_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] ad;
  logic [7:0]  cbe;
  logic        addr_vld, data_vld, drive, wide;
  logic        par_in, par64_in, perr_en, serr_en, clr_dpe, clr_sse;
  logic        par_o, par_oe_o, par64_o, par64_oe_o;
  logic        perr_o, serr_o, sts_dpe_o, sts_sse_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference model state
  bit m_par, m_oe, m_par64, m_oe64, m_perr, m_serr, m_dpe, m_sse;
  bit p_drv, p_addr, p_data, p_wide, p_par, p_par64;

  always #4 clk = ~clk;

  pci_par_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ad_i      (ad),
    .cbe_i     (cbe),
    .addr_vld_i(addr_vld),
    .data_vld_i(data_vld),
    .drive_i   (drive),
    .wide_i    (wide),
    .par_in_i  (par_in),
    .par64_in_i(par64_in),
    .perr_en_i (perr_en),
    .serr_en_i (serr_en),
    .clr_dpe_i (clr_dpe),
    .clr_sse_i (clr_sse),
    .par_o     (par_o),
    .par_oe_o  (par_oe_o),
    .par64_o   (par64_o),
    .par64_oe_o(par64_oe_o),
    .perr_o    (perr_o),
    .serr_o    (serr_o),
    .sts_dpe_o (sts_dpe_o),
    .sts_sse_o (sts_sse_o)
  );

  function automatic bit even_bit(input logic [31:0] a, input logic [3:0] b);
    int ones;
    ones = $countones(a) + $countones(b);
    return (ones % 2) == 1;
  endfunction

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  // advance the model by one clock edge, using the inputs now applied
  task automatic model_tick();
    bit rx, mm, derr, aerr, cur_lo, cur_hi;
    rx   = !p_drv && (p_addr || p_data);
    mm   = (par_in != p_par) || (p_wide && (par64_in != p_par64));
    derr = rx && p_data && mm;
    aerr = rx && p_addr && mm;
    m_perr = derr && perr_en;
    m_serr = aerr && serr_en;
    if (derr || aerr) m_dpe = 1'b1;
    else if (clr_dpe) m_dpe = 1'b0;
    if (aerr && serr_en) m_sse = 1'b1;
    else if (clr_sse) m_sse = 1'b0;
    cur_lo  = even_bit(ad[31:0], cbe[3:0]);
    cur_hi  = even_bit(ad[63:32], cbe[7:4]);
    m_oe    = drive;
    m_par   = drive ? cur_lo : 1'b0;
    m_oe64  = drive && wide;
    m_par64 = (drive && wide) ? cur_hi : 1'b0;
    p_drv = drive; p_addr = addr_vld; p_data = data_vld; p_wide = wide;
    p_par = cur_lo; p_par64 = cur_hi;
  endtask

  task automatic run_cycle();
    model_tick();
    @(posedge clk);
    @(negedge clk);
    chk("R2", "par_o", par_o, m_par);
    chk("R3", "par_oe_o", par_oe_o, m_oe);
    chk("R4", "par64_o", par64_o, m_par64);
    chk("R4", "par64_oe_o", par64_oe_o, m_oe64);
    chk("R5 R6 R10", "perr_o", perr_o, m_perr);
    chk("R5 R7 R10", "serr_o", serr_o, m_serr);
    chk("R8 R9", "sts_dpe_o", sts_dpe_o, m_dpe);
    chk("R8 R9", "sts_sse_o", sts_sse_o, m_sse);
  endtask

  task automatic cyc(input logic [63:0] a, input logic [7:0] c, input bit av, input bit dv,
                     input bit drv, input bit w, input bit inj, input bit inj64,
                     input bit pe, input bit se, input bit cd, input bit cs);
    ad = a; cbe = c; addr_vld = av; data_vld = dv; drive = drv; wide = w;
    par_in = p_par ^ inj; par64_in = p_par64 ^ inj64;
    perr_en = pe; serr_en = se; clr_dpe = cd; clr_sse = cs;
    run_cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ad = '0; cbe = '0; addr_vld = 0; data_vld = 0; drive = 0; wide = 0;
    par_in = 0; par64_in = 0; perr_en = 0; serr_en = 0; clr_dpe = 0; clr_sse = 0;
    {m_par, m_oe, m_par64, m_oe64, m_perr, m_serr, m_dpe, m_sse} = '0;
    {p_drv, p_addr, p_data, p_wide, p_par, p_par64} = '0;
    repeat (3) @(negedge clk);
    // R1: everything low under reset, even with busy inputs
    ad = 64'hFFFF_0000_1234_8765; cbe = 8'hA5; drive = 1; wide = 1; data_vld = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "par_o", par_o, 1'b0);
    chk("R1", "par_oe_o", par_oe_o, 1'b0);
    chk("R1", "par64_o", par64_o, 1'b0);
    chk("R1", "par64_oe_o", par64_oe_o, 1'b0);
    chk("R1", "perr_o", perr_o, 1'b0);
    chk("R1", "serr_o", serr_o, 1'b0);
    chk("R1", "sts_dpe_o", sts_dpe_o, 1'b0);
    chk("R1", "sts_sse_o", sts_sse_o, 1'b0);
    ad = '0; cbe = '0; drive = 0; wide = 0; data_vld = 0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3: local address phase (command on C/BE), then a wide data phase
    cyc(64'h0000_0000_1234_5678, 8'h0B, 1, 0, 1, 0, 0, 0, 1, 1, 0, 0);
    // R4: wide drive; corrupt sampled parity after own cycle (R10: ignored)
    cyc(64'hFFFF_FFFF_DEAD_BEEF, 8'hF0, 0, 1, 1, 1, 1, 1, 1, 1, 0, 0);
    // R10: parity after own data phase ignored; receive narrow data
    cyc(64'h0000_00FF_0000_0001, 8'h0E, 0, 1, 0, 0, 1, 1, 1, 1, 0, 0);
    // R5: correct parity for received data; receive wide data next
    cyc(64'h8000_0001_7FFF_FFFE, 8'h3C, 0, 1, 0, 1, 0, 0, 1, 1, 0, 0);
    // R5 R6: high-half only error on wide transfer -> perr
    cyc(64'h0, 8'h0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    // receive address phase (config-style, undefined lines set)
    cyc(64'h0000_0000_00AB_CD01, 8'h0A, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    // R7 R8: bad address parity -> serr, both status bits
    cyc(64'h0000_0000_5555_AAAA, 8'h0F, 0, 1, 0, 0, 1, 0, 1, 1, 0, 0);
    // R6: data error with response disabled -> no perr, status stays
    cyc(64'h0000_0000_0F0F_0F0F, 8'h01, 0, 1, 0, 0, 1, 0, 0, 1, 0, 0);
    // R5 R9: narrow transfer ignores par64_in; clear both status bits
    cyc(64'h0, 8'h0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1);
    cyc(64'h0, 8'h0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    // R7 R8: address error with serr disabled -> dpe only
    cyc(64'h0000_0000_1111_2222, 8'h06, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc(64'h0, 8'h0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    // R9: error in the same cycle as a clear strobe keeps the bit set
    cyc(64'h0000_0000_0000_0003, 8'h00, 0, 1, 0, 0, 0, 0, 1, 1, 0, 0);
    cyc(64'h0, 8'h0, 0, 0, 0, 0, 1, 0, 1, 1, 1, 0);
    cyc(64'h0, 8'h0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      cyc({$urandom, $urandom}, 8'($urandom),
          ($urandom % 4) == 0, ($urandom % 2) == 0,
          ($urandom % 3) == 0, ($urandom % 2) == 0,
          ($urandom % 5) == 0, ($urandom % 5) == 0,
          ($urandom % 4) != 0, ($urandom % 4) != 0,
          ($urandom % 9) == 0, ($urandom % 9) == 0);
    end
    finish_run();
  end

endmodule